// File: doc/BRIEF.md
# DMA Request Arbiter for an 8/16-bit I/O Channel

This block sits on the host side of a PC/104-style I/O channel. It accepts DMA requests from peripherals on seven channel slots and hands the bus to one of them at a time. The channel numbering skips 4. Slots for channels 0 to 3 move bytes, and slots for channels 5 to 7 move 16-bit words. Requests arrive asynchronously, so each one passes through a two-flop synchroniser. Only while the bus is idle does a fixed-priority picker choose the lowest-numbered pending channel.

While a grant is active, the chosen channel sees its active-low acknowledge. The address enable output is high, which takes the CPU off the channel. The address-latch enable output is held high, and a flag reports whether the granted channel is a 16-bit one. The grant lasts until the transfer datapath pulses transfer-done. The arbiter then releases the acknowledge and stays idle for at least one clock before it grants again.

Bit i of the request and acknowledge vectors stands for channel i when i is 0 to 3, and for channel i+1 when i is 4 to 6.

Top module: `dma_req_arbiter`

## Requirements
- R1: While reset is asserted, and after it is released with no request pending, every acknowledge is high and the address enable, address-latch enable and width flag are all low.
- R2: Acknowledges are active low, and at most one of the seven is low at any time. Bit i maps to channel i for i = 0..3 and to channel i+1 for i = 4..6.
- R3: When the bus is idle and a request is set up before rising edge k and held, its acknowledge goes low after rising edge k+2 (two synchroniser edges plus one decision edge).
- R4: The width flag is high during a grant to bits 4..6 (channels 5..7) and low during a grant to bits 0..3 (channels 0..3) and when idle.
- R5: Once low, an acknowledge stays low on the same bit until transfer-done is sampled high on a rising edge, and it goes high after that edge.
- R6: Address enable is high exactly while some acknowledge is low.
- R7: Address-latch enable is high exactly while some acknowledge is low.
- R8: After an acknowledge is released, all acknowledges stay high for at least one full clock before the next one goes low.
- R9: Among requests pending in the synchroniser output at the decision edge, the lowest bit index wins.
- R10: A grant is never pre-empted. A higher-priority request that arrives during a grant waits until the bus is idle.
- R11: A request that is raised and then dropped before it is sampled at an idle decision edge is treated as withdrawn and is never acknowledged.
- R12: Transfer-done sampled while the bus is idle has no effect, including in the same edge where a new grant is taken.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| dreq_i | input | 7 | Asynchronous active-high DMA requests, one per channel slot |
| xfer_done_i | input | 1 | One-clock pulse from the datapath that ends the current transfer |
| dack_n_o | output | 7 | Active-low acknowledges, one per channel slot |
| aen_o | output | 1 | Address enable: high during a DMA grant, low for CPU cycles |
| bale_o | output | 1 | Address-latch enable, forced high during a DMA grant |
| wide_o | output | 1 | High when the granted channel is a 16-bit channel |

## Verification
The bench raises requests on high- and low-priority slots together and expects the lowest bit to win. It also raises a higher-priority request in the middle of a grant. A design without priority, or one that samples during a grant, would hand the bus to the wrong slot or switch it mid-transfer. The bench drops a request while another channel holds the bus, to catch a design that remembers stale requests. It lines up transfer-done with the very edge where an idle bus takes a grant, to catch a design that acts on done outside a grant. It also measures the cycle of the first acknowledge and the idle gap after a release, to catch a missing synchroniser stage, a combinational shortcut, or back-to-back grants with no recovery clock.

// File: rtl/dma_arb_pkg.sv
package dma_arb_pkg;

  // Arbiter bus state: idle (CPU owns the channel) or granted to one slot
  typedef enum logic {
    ARB_IDLE  = 1'b0,
    ARB_GRANT = 1'b1
  } arb_state_e;

endpackage

// File: rtl/dma_req_sync.sv
// Multi-stage synchroniser for a vector of asynchronous request lines.
module dma_req_sync #(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  logic [WIDTH-1:0] pipe_q [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) begin
        pipe_q[s] <= '0;
      end
    end else begin
      pipe_q[0] <= async_i;
      for (int s = 1; s < STAGES; s++) begin
        pipe_q[s] <= pipe_q[s-1];
      end
    end
  end

  assign sync_o = pipe_q[STAGES-1];

endmodule

// File: rtl/dma_prio_pick.sv
// Fixed-priority picker: isolates the lowest set bit of the request vector.
module dma_prio_pick #(
  parameter int unsigned WIDTH = 7
) (
  input  logic [WIDTH-1:0] req_i,
  output logic [WIDTH-1:0] pick_o,
  output logic             any_o
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  // Two's complement isolation of the lowest set bit
  assign pick_o = req_i & (~req_i + ONE);
  assign any_o  = |req_i;

endmodule

// File: rtl/dma_grant_fsm.sv
// Grant state machine: loads a one-hot grant when idle and holds it until done.
module dma_grant_fsm
  import dma_arb_pkg::*;
#(
  parameter int unsigned WIDTH  = 7,
  parameter int unsigned NARROW = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] pick_i,
  input  logic             pick_any_i,
  input  logic             done_i,
  output logic             busy_o,
  output logic [WIDTH-1:0] grant_o,
  output logic             wide_o
);

  arb_state_e       state_q, state_d;
  logic [WIDTH-1:0] grant_q;
  logic             wide_q;
  logic             load;

  // Next-state process
  always_comb begin
    state_d = state_q;
    load    = 1'b0;
    unique case (state_q)
      ARB_IDLE: begin
        if (pick_any_i) begin
          state_d = ARB_GRANT;
          load    = 1'b1;
        end
      end
      ARB_GRANT: begin
        if (done_i) begin
          state_d = ARB_IDLE;
        end
      end
      default: state_d = ARB_IDLE;
    endcase
  end

  // Register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ARB_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant_q <= '0;
      wide_q  <= 1'b0;
    end else if (load) begin
      grant_q <= pick_i;
      wide_q  <= |pick_i[WIDTH-1:NARROW];
    end
  end

  assign busy_o  = (state_q == ARB_GRANT);
  assign grant_o = grant_q;
  assign wide_o  = busy_o & wide_q;

  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i) |=> (busy_o && $stable(grant_q))); // R5

  AST_RELEASE_ON_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && done_i) |=> !busy_o); // R5

  AST_ONE_HOT_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> $onehot(grant_q)); // R2

  AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && !done_i) |=> $stable(wide_o)); // R10

endmodule

// File: rtl/dma_req_arbiter.sv
// DMA request arbiter: synchronise, pick lowest channel, grant until done.
module dma_req_arbiter #(
  parameter int unsigned NARROW_CH   = 4,
  parameter int unsigned WIDE_CH     = 3,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic [NARROW_CH+WIDE_CH-1:0]   dreq_i,
  input  logic                           xfer_done_i,
  output logic [NARROW_CH+WIDE_CH-1:0]   dack_n_o,
  output logic                           aen_o,
  output logic                           bale_o,
  output logic                           wide_o
);

  localparam int unsigned     NSLOT = NARROW_CH + WIDE_CH;
  localparam logic [NSLOT-1:0] ONE  = NSLOT'(1);

  logic [NSLOT-1:0] req_s;
  logic [NSLOT-1:0] pick;
  logic             pick_any;
  logic             busy;
  logic [NSLOT-1:0] grant;
  logic             wide;

  dma_req_sync #(
    .WIDTH  (NSLOT),
    .STAGES (SYNC_STAGES)
  ) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (dreq_i),
    .sync_o  (req_s)
  );

  dma_prio_pick #(
    .WIDTH (NSLOT)
  ) u_pick (
    .req_i  (req_s),
    .pick_o (pick),
    .any_o  (pick_any)
  );

  dma_grant_fsm #(
    .WIDTH  (NSLOT),
    .NARROW (NARROW_CH)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .pick_i     (pick),
    .pick_any_i (pick_any),
    .done_i     (xfer_done_i),
    .busy_o     (busy),
    .grant_o    (grant),
    .wide_o     (wide)
  );

  assign dack_n_o = ~(grant & {NSLOT{busy}});
  assign aen_o    = busy;
  assign bale_o   = busy;
  assign wide_o   = wide;

  AST_AEN_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    aen_o == !(&dack_n_o)); // R6

  AST_BALE_WITH_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    bale_o == !(&dack_n_o)); // R7

  AST_WIDE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
    wide_o == !(&dack_n_o[NSLOT-1:NARROW_CH])); // R4

  AST_GRANT_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> |($past(req_s) & grant)); // R11

  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (($past(req_s) & (grant - ONE)) == '0)); // R9

  AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(aen_o) |-> (&dack_n_o)); // R8

endmodule

// File: tb/dma_req_arbiter_tb.sv
module dma_req_arbiter_tb;

  logic       clk;
  logic       rst_n;
  logic [6:0] dreq;
  logic       done;
  logic [6:0] dack_n;
  logic       aen, bale, wide;

  int n_cmp = 0;
  int n_bad = 0;

  dma_req_arbiter u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .dreq_i      (dreq),
    .xfer_done_i (done),
    .dack_n_o    (dack_n),
    .aen_o       (aen),
    .bale_o      (bale),
    .wide_o      (wide)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk; // 50 MHz

  // Behavioural reference model
  logic [6:0] m_s1, m_s2;
  bit         m_busy;
  int         m_slot;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 = '0; m_s2 = '0; m_busy = 0; m_slot = 0;
    end else begin
      int pk;
      pk = -1;
      for (int i = 6; i >= 0; i--) if (m_s2[i]) pk = i;
      if (!m_busy) begin
        if (pk >= 0) begin m_busy = 1; m_slot = pk; end
      end else if (done) begin
        m_busy = 0;
      end
      m_s2 = m_s1;
      m_s1 = dreq;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Compare against the model on every clock, away from the rising edge
  always @(negedge clk) begin
    if (rst_n) begin
      logic [6:0] e_dack;
      e_dack = m_busy ? ~(7'b1 << m_slot) : 7'h7f;
      chk("R2/R5 model dack", {25'b0, dack_n}, {25'b0, e_dack});
      chk("R6 model aen", {31'b0, aen}, {31'b0, m_busy});
      chk("R7 model bale", {31'b0, bale}, {31'b0, m_busy});
      chk("R4 model wide", {31'b0, wide}, {31'b0, (m_busy && m_slot >= 4)});
    end
  end

  task automatic tick();
    @(posedge clk);
    #5;
  endtask

  task automatic pulse_done();
    tick(); done = 1'b1;
    tick(); done = 1'b0;
  endtask

  task automatic wait_ack(output int cyc);
    cyc = 0;
    do begin
      @(negedge clk);
      cyc++;
    end while ((&dack_n) && cyc < 12);
  endtask

  task automatic report();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL R5 watchdog actual=hung expected=finished");
    report();
  end

  initial begin
    int cyc;
    rst_n = 1'b0; dreq = '0; done = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset dack", {25'b0, dack_n}, 32'h7f);
    chk("R1 reset aen/bale/wide", {29'b0, aen, bale, wide}, 32'h0);
    tick(); rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 idle after reset", {25'b0, dack_n}, 32'h7f);

    // R3 latency: request set before edge k, ack visible at 4th negedge
    tick(); dreq = 7'b000_0100;
    wait_ack(cyc);
    chk("R3 ack latency", cyc, 4);
    chk("R2 ack on bit2", {25'b0, dack_n}, {25'b0, ~7'b000_0100});
    chk("R4 narrow width", {31'b0, wide}, 32'h0);
    chk("R6 aen during grant", {31'b0, aen}, 32'h1);
    chk("R7 bale during grant", {31'b0, bale}, 32'h1);
    tick(); dreq = '0;
    repeat (3) tick();
    chk("R5 held without done", {25'b0, dack_n}, {25'b0, ~7'b000_0100});
    pulse_done();
    @(negedge clk);
    chk("R5 released after done", {25'b0, dack_n}, 32'h7f);

    // R9 priority between ch6 and ch7 slots, R4 wide grant
    repeat (2) tick();
    dreq = 7'b110_0000;
    wait_ack(cyc);
    chk("R9 lowest of bits 5,6", {25'b0, dack_n}, {25'b0, ~7'b010_0000});
    chk("R4 wide grant", {31'b0, wide}, 32'h1);
    // R10: higher-priority arrival during grant waits
    tick(); dreq = 7'b110_0001;
    repeat (5) tick();
    chk("R10 no preemption", {25'b0, dack_n}, {25'b0, ~7'b010_0000});
    dreq = 7'b100_0001;
    pulse_done();
    @(negedge clk);
    chk("R8 idle gap after release", {25'b0, dack_n}, 32'h7f);
    @(negedge clk);
    chk("R9 bit0 wins after gap", {25'b0, dack_n}, {25'b0, ~7'b000_0001});
    tick(); dreq = 7'b100_0000;
    pulse_done();
    wait_ack(cyc);
    chk("R9 remaining bit6 served", {25'b0, dack_n}, {25'b0, ~7'b100_0000});
    tick(); dreq = '0;
    pulse_done();
    repeat (3) tick();

    // R11: request dropped while another channel holds the bus
    dreq = 7'b000_0010;
    wait_ack(cyc);
    chk("R11 setup grant bit1", {25'b0, dack_n}, {25'b0, ~7'b000_0010});
    tick(); dreq = 7'b000_1000;
    repeat (3) tick();
    dreq = '0;
    repeat (4) tick();
    pulse_done();
    for (int i = 0; i < 6; i++) begin
      @(negedge clk);
      chk("R11 withdrawn not granted", {25'b0, dack_n}, 32'h7f);
    end

    // R12: done in the idle decision edge is ignored
    tick(); dreq = 7'b001_0000;
    tick();
    tick(); done = 1'b1;
    tick(); done = 1'b0;
    @(negedge clk);
    chk("R12 grant taken despite done", {25'b0, dack_n}, {25'b0, ~7'b001_0000});
    chk("R4 ch5 is wide", {31'b0, wide}, 32'h1);
    repeat (2) @(negedge clk);
    chk("R12 grant still held", {25'b0, dack_n}, {25'b0, ~7'b001_0000});
    tick(); dreq = '0;
    pulse_done();
    repeat (2) tick();
    chk("R12 idle at end", {25'b0, dack_n}, 32'h7f);
    report();
  end

endmodule